// File: doc/BRIEF.md
# I2C Master Byte Receiver with Acknowledge

This block is the receive half of an I2C bus master. A reload register sets the length of one SCL half-period in system clocks. When the CPU issues a receive command, the block clocks in one byte from SDA, most significant bit first, while leaving SDA released. After the eighth falling edge of SCL it holds SCL low, places the byte in a holding buffer, and raises the buffer-full and interrupt flags. The CPU reads the byte and then issues an acknowledge command. That command drives one more SCL clock, with SDA pulled low for ACK or released for NACK.

Every high phase starts counting only after SCL is actually seen high on the pin. A slave that stretches the clock by holding SCL low therefore lengthens the bus cycle without shortening the high time. The sequencer has seven states. IDLE goes to RX_LOW on a receive command and to ACK_LOW on an acknowledge command; the receive command wins if both arrive together. RX_LOW goes to RX_WAIT on a counter rollover. RX_WAIT goes to RX_HIGH when SCL is seen high, and SDA is sampled on that transition. RX_HIGH goes to RX_LOW on a rollover, or to IDLE after the eighth bit. ACK_LOW goes to ACK_WAIT on a rollover, ACK_WAIT goes to ACK_HIGH when SCL is seen high, and ACK_HIGH goes to IDLE on a rollover. On both returns to IDLE, SCL is parked low. The SCL and SDA pin inputs are taken to be already synchronous to the clock.

Top module: `iic_byte_receiver`

## Requirements
- R1: One counter period lasts reload+1 clocks. The first SCL low phase after a receive command lasts exactly reload+1 clocks, and each high phase lasts reload+1 clocks after the cycle in which SCL is first seen high.
- R2: A receive command in IDLE shifts in 8 bits, MSB first. Each bit is sampled from SDA once, in the cycle where SCL is first seen high. SDA is never pulled low during reception.
- R3: At the eighth falling SCL edge, the receive-busy output clears and SCL stays pulled low. The buffer is loaded with the byte, and buffer-full and interrupt are set.
- R4: A buffer read strobe clears buffer-full on the next clock.
- R5: If a byte completes while buffer-full is already set, the overflow flag is set and the buffer keeps the previous byte.
- R6: A buffer write during reception sets the write-collision flag and leaves the buffer unchanged. A buffer write at any other time loads the buffer and leaves the flags as they are.
- R7: An acknowledge command in IDLE pulls SCL low for reload+1 clocks. It then releases SCL, waits until SCL is seen high, and holds it high for reload+1 clocks. Finally it pulls SCL low and returns to IDLE. SDA is pulled low during all of this when the ack bit is 0, and released when it is 1.
- R8: While SCL is held low by another device, the sequencer waits, and high-phase timing does not start.
- R9: Commands given while busy are ignored. When both commands arrive in IDLE in the same cycle, only the receive starts.
- R10: Overflow, write-collision and interrupt stay set until their clear strobe. A set event in the same cycle as a clear wins.
- R11: After reset, SCL and SDA are released, all flags are 0, the buffer is 0, and the reload value equals the RELOAD_RST parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reload_we | input | 1 | Write strobe for the half-period reload value |
| reload_wdata | input | CNT_W | New reload value |
| rcv_go | input | 1 | Receive command strobe |
| ack_go | input | 1 | Acknowledge command strobe |
| ack_bit | input | 1 | Acknowledge value: 0 = ACK, 1 = NACK |
| buf_wr | input | 1 | CPU write strobe to the holding buffer |
| buf_wdata | input | DATA_W | CPU write data |
| buf_rd | input | 1 | CPU read strobe of the holding buffer |
| clr_ovf | input | 1 | Clears the overflow flag |
| clr_wcol | input | 1 | Clears the write-collision flag |
| clr_irq | input | 1 | Clears the interrupt flag |
| rd_data | output | DATA_W | Holding buffer contents |
| buf_full | output | 1 | Buffer-full flag |
| ovf_flag | output | 1 | Overflow flag |
| wcol_flag | output | 1 | Write-collision flag |
| irq_flag | output | 1 | Interrupt flag |
| rcv_busy | output | 1 | Receive in progress |
| ack_busy | output | 1 | Acknowledge in progress |
| scl_i | input | 1 | SCL pin level |
| scl_low_o | output | 1 | Pull SCL low when 1 |
| sda_i | input | 1 | SDA pin level |
| sda_low_o | output | 1 | Pull SDA low when 1 |

## Verification
A command strobe takes effect at the next clock edge. From that edge, the first SCL release comes reload+1 clocks later. After the release, one cycle is spent seeing SCL high, and then reload+1 clocks of high time follow. Completion flags and the parked SCL appear in the cycle after the final rollover, and a read or clear strobe acts one clock after it is sampled. The bench keeps a behavioural model that is stepped on every rising edge with the same pin and strobe inputs. It compares every output against that model on every falling edge, so each result is checked in exactly the cycle it is due. Scenario checks add explicit phase-length counts, stretching, overflow, collision and ignored commands.

// File: rtl/iicr_pkg.sv
package iicr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_RX_LOW   = 3'd1,
        ST_RX_WAIT  = 3'd2,
        ST_RX_HIGH  = 3'd3,
        ST_ACK_LOW  = 3'd4,
        ST_ACK_WAIT = 3'd5,
        ST_ACK_HIGH = 3'd6
    } iicr_state_e;

endpackage

// File: rtl/iicr_baud.sv
module iicr_baud #(
    parameter int CNT_W      = 8,
    parameter int RELOAD_RST = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] reload,
    output logic             tick
);

    logic [CNT_W-1:0] cnt_q;

    assign tick = run && (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= CNT_W'(RELOAD_RST);
        end else if (!run || tick) begin
            cnt_q <= reload;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // R1: a rollover restarts the period from the reload value
    p_reload_after_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt_q == $past(reload)));

    // R1: a stopped counter sits at the reload value
    p_idle_holds_reload_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == $past(reload)));

endmodule

// File: rtl/iicr_seq.sv
module iicr_seq
    import iicr_pkg::*;
#(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rcv_go,
    input  logic            ack_go,
    input  logic            ack_bit,
    input  logic            tick,
    input  logic            scl_i,
    input  logic            sda_i,
    output logic            run,
    output logic            scl_low_o,
    output logic            sda_low_o,
    output logic            rcv_busy,
    output logic            ack_busy,
    output logic            done,
    output logic [BITS-1:0] shift_q
);

    localparam int CW = (BITS > 1) ? $clog2(BITS) : 1;

    iicr_state_e   state_q, state_d;
    logic [CW-1:0] bit_cnt_q;
    logic          park_q;
    logic          ackv_q;
    logic          last_bit;

    assign last_bit = (bit_cnt_q == CW'(BITS - 1));

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (rcv_go)      state_d = ST_RX_LOW;
                else if (ack_go) state_d = ST_ACK_LOW;
            end
            ST_RX_LOW:   if (tick)  state_d = ST_RX_WAIT;
            ST_RX_WAIT:  if (scl_i) state_d = ST_RX_HIGH;
            ST_RX_HIGH:  if (tick)  state_d = last_bit ? ST_IDLE : ST_RX_LOW;
            ST_ACK_LOW:  if (tick)  state_d = ST_ACK_WAIT;
            ST_ACK_WAIT: if (scl_i) state_d = ST_ACK_HIGH;
            ST_ACK_HIGH: if (tick)  state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q <= '0;
            shift_q   <= '0;
            park_q    <= 1'b0;
            ackv_q    <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && rcv_go) begin
                bit_cnt_q <= '0;
            end else if (state_q == ST_RX_HIGH && tick && !last_bit) begin
                bit_cnt_q <= bit_cnt_q + 1'b1;
            end
            if (state_q == ST_RX_WAIT && scl_i) begin
                shift_q <= {shift_q[BITS-2:0], sda_i};
            end
            if (state_q == ST_IDLE && !rcv_go && ack_go) begin
                ackv_q <= ack_bit;
            end
            if (done || (state_q == ST_ACK_HIGH && tick)) begin
                park_q <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        run       = 1'b0;
        scl_low_o = 1'b0;
        sda_low_o = 1'b0;
        rcv_busy  = 1'b0;
        ack_busy  = 1'b0;
        unique case (state_q)
            ST_IDLE:     scl_low_o = park_q;
            ST_RX_LOW:   begin run = 1'b1; scl_low_o = 1'b1; rcv_busy = 1'b1; end
            ST_RX_WAIT:  rcv_busy = 1'b1;
            ST_RX_HIGH:  begin run = 1'b1; rcv_busy = 1'b1; end
            ST_ACK_LOW:  begin run = 1'b1; scl_low_o = 1'b1; ack_busy = 1'b1; sda_low_o = !ackv_q; end
            ST_ACK_WAIT: begin ack_busy = 1'b1; sda_low_o = !ackv_q; end
            ST_ACK_HIGH: begin run = 1'b1; ack_busy = 1'b1; sda_low_o = !ackv_q; end
            default:     scl_low_o = 1'b0;
        endcase
    end

    assign done = (state_q == ST_RX_HIGH) && tick && last_bit;

    // R2: SDA left released while bits come in
    p_sda_free_rx_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rcv_busy |-> !sda_low_o);

    // R8: high-phase timing waits for the pin
    p_wait_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RX_WAIT && !scl_i) |=> (state_q == ST_RX_WAIT));

    // R7: acknowledge ends with SCL pulled low
    p_ack_parks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_busy) |-> scl_low_o);

endmodule

// File: rtl/iicr_status.sv
module iicr_status #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic [DATA_W-1:0] shift_byte,
    input  logic              rcv_busy,
    input  logic              buf_wr,
    input  logic [DATA_W-1:0] buf_wdata,
    input  logic              buf_rd,
    input  logic              clr_ovf,
    input  logic              clr_wcol,
    input  logic              clr_irq,
    output logic [DATA_W-1:0] buf_q,
    output logic              full_q,
    output logic              ovf_q,
    output logic              wcol_q,
    output logic              irq_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q  <= '0;
            full_q <= 1'b0;
            ovf_q  <= 1'b0;
            wcol_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            if (done) begin
                if (!full_q) buf_q <= shift_byte;
            end else if (buf_wr && !rcv_busy) begin
                buf_q <= buf_wdata;
            end
            full_q <= (done && !full_q) || (full_q && !buf_rd);
            ovf_q  <= (ovf_q && !clr_ovf) || (done && full_q);
            wcol_q <= (wcol_q && !clr_wcol) || (buf_wr && rcv_busy);
            irq_q  <= (irq_q && !clr_irq) || done;
        end
    end

endmodule

// File: rtl/iic_byte_receiver.sv
module iic_byte_receiver #(
    parameter int CNT_W      = 8,
    parameter int RELOAD_RST = 4,
    parameter int DATA_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reload_we,
    input  logic [CNT_W-1:0]  reload_wdata,
    input  logic              rcv_go,
    input  logic              ack_go,
    input  logic              ack_bit,
    input  logic              buf_wr,
    input  logic [DATA_W-1:0] buf_wdata,
    input  logic              buf_rd,
    input  logic              clr_ovf,
    input  logic              clr_wcol,
    input  logic              clr_irq,
    output logic [DATA_W-1:0] rd_data,
    output logic              buf_full,
    output logic              ovf_flag,
    output logic              wcol_flag,
    output logic              irq_flag,
    output logic              rcv_busy,
    output logic              ack_busy,
    input  logic              scl_i,
    output logic              scl_low_o,
    input  logic              sda_i,
    output logic              sda_low_o
);

    logic [CNT_W-1:0]  reload_q;
    logic              run, tick, done;
    logic [DATA_W-1:0] shift_byte;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         reload_q <= CNT_W'(RELOAD_RST);
        else if (reload_we) reload_q <= reload_wdata;
    end

    iicr_baud #(.CNT_W(CNT_W), .RELOAD_RST(RELOAD_RST)) u_baud (
        .clk(clk), .rst_n(rst_n), .run(run), .reload(reload_q), .tick(tick)
    );

    iicr_seq #(.BITS(DATA_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .rcv_go(rcv_go), .ack_go(ack_go),
        .ack_bit(ack_bit), .tick(tick), .scl_i(scl_i), .sda_i(sda_i),
        .run(run), .scl_low_o(scl_low_o), .sda_low_o(sda_low_o),
        .rcv_busy(rcv_busy), .ack_busy(ack_busy), .done(done),
        .shift_q(shift_byte)
    );

    iicr_status #(.DATA_W(DATA_W)) u_status (
        .clk(clk), .rst_n(rst_n), .done(done), .shift_byte(shift_byte),
        .rcv_busy(rcv_busy), .buf_wr(buf_wr), .buf_wdata(buf_wdata),
        .buf_rd(buf_rd), .clr_ovf(clr_ovf), .clr_wcol(clr_wcol),
        .clr_irq(clr_irq), .buf_q(rd_data), .full_q(buf_full),
        .ovf_q(ovf_flag), .wcol_q(wcol_flag), .irq_q(irq_flag)
    );

    // R3: completion leaves SCL parked low with the flags raised
    p_done_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rcv_busy) |-> (buf_full && irq_flag && scl_low_o));

    // R5: overflow only appears when a byte completes
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> $fell(rcv_busy));

    // R6: a write during reception is flagged
    p_wcol_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_wr && rcv_busy) |=> wcol_flag);

    // R4: a read outside reception empties the buffer
    p_rd_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_rd && !rcv_busy) |=> !buf_full);

    // R9: a receive command during acknowledge does not start
    p_busy_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_busy && rcv_go) |=> !rcv_busy);

endmodule

// File: tb/iic_byte_receiver_tb.sv
`timescale 1ns/1ps
module iic_byte_receiver_tb_top;

    localparam int RLD_RST = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reload_we = 1'b0;
    logic [7:0] reload_wdata = '0;
    logic       rcv_go = 1'b0, ack_go = 1'b0, ack_bit = 1'b0;
    logic       buf_wr = 1'b0, buf_rd = 1'b0;
    logic [7:0] buf_wdata = '0;
    logic       clr_ovf = 1'b0, clr_wcol = 1'b0, clr_irq = 1'b0;
    logic [7:0] rd_data;
    logic       buf_full, ovf_flag, wcol_flag, irq_flag, rcv_busy, ack_busy;
    logic       scl_i, scl_low_o, sda_i, sda_low_o;

    logic       stretch = 1'b0, stretch_en = 1'b0;
    logic       slv_sda_low = 1'b0, slv_on = 1'b0;
    logic [7:0] slv_byte = '0;
    int         slv_rises = 0;

    int total = 0, bad = 0;

    always #4 clk = ~clk;

    assign scl_i = !(scl_low_o || stretch);
    assign sda_i = !(sda_low_o || slv_sda_low);

    iic_byte_receiver #(.CNT_W(8), .RELOAD_RST(RLD_RST), .DATA_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .reload_we(reload_we), .reload_wdata(reload_wdata),
        .rcv_go(rcv_go), .ack_go(ack_go), .ack_bit(ack_bit), .buf_wr(buf_wr),
        .buf_wdata(buf_wdata), .buf_rd(buf_rd), .clr_ovf(clr_ovf),
        .clr_wcol(clr_wcol), .clr_irq(clr_irq), .rd_data(rd_data),
        .buf_full(buf_full), .ovf_flag(ovf_flag), .wcol_flag(wcol_flag),
        .irq_flag(irq_flag), .rcv_busy(rcv_busy), .ack_busy(ack_busy),
        .scl_i(scl_i), .scl_low_o(scl_low_o), .sda_i(sda_i), .sda_low_o(sda_low_o)
    );

    // slave that serves one byte, MSB first
    always @(posedge scl_i) if (slv_on) slv_rises++;
    always @(negedge scl_i) begin
        if (slv_on && slv_rises > 0) begin
            if (slv_rises < 8) slv_sda_low = !slv_byte[7 - slv_rises];
            else begin slv_sda_low = 1'b0; slv_on = 1'b0; end
        end
    end
    always @(negedge scl_i) begin
        if (stretch_en) begin
            stretch = 1'b1;
            repeat (5) @(negedge clk);
            stretch = 1'b0;
        end
    end

    // behavioural reference: 0 idle,1 rx low,2 rx wait,3 rx high,4 ack low,5 ack wait,6 ack high
    int m_mode, m_tmr, m_bits, m_reload, nm;
    logic [7:0] m_sh, m_buf;
    logic m_full, m_ovf, m_wcol, m_irq, m_park, m_ackv, m_run, m_tick, m_done;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = 0; m_tmr = RLD_RST; m_bits = 0; m_reload = RLD_RST;
            m_sh = '0; m_buf = '0; m_full = 0; m_ovf = 0; m_wcol = 0;
            m_irq = 0; m_park = 0; m_ackv = 0;
        end else begin
            m_run  = (m_mode == 1 || m_mode == 3 || m_mode == 4 || m_mode == 6);
            m_tick = m_run && (m_tmr == 0);
            m_done = 0;
            nm = m_mode;
            case (m_mode)
                0: if (rcv_go) begin nm = 1; m_bits = 0; end
                   else if (ack_go) begin nm = 4; m_ackv = ack_bit; end
                1: if (m_tick) nm = 2;
                2: if (scl_i) begin nm = 3; m_sh = {m_sh[6:0], sda_i}; end
                3: if (m_tick) begin
                       if (m_bits == 7) begin nm = 0; m_done = 1; m_park = 1; end
                       else begin nm = 1; m_bits++; end
                   end
                4: if (m_tick) nm = 5;
                5: if (scl_i) nm = 6;
                6: if (m_tick) begin nm = 0; m_park = 1; end
                default: nm = 0;
            endcase
            if (!m_run || m_tick) m_tmr = m_reload; else m_tmr--;
            if (clr_ovf)  m_ovf = 0;
            if (clr_wcol) m_wcol = 0;
            if (clr_irq)  m_irq = 0;
            if (buf_wr) begin
                if (m_mode >= 1 && m_mode <= 3) m_wcol = 1;
                else m_buf = buf_wdata;
            end
            if (m_done && !m_full) begin
                m_full = 1; m_buf = m_sh;
            end else begin
                if (m_done) m_ovf = 1;
                if (buf_rd) m_full = 0;
            end
            if (m_done) m_irq = 1;
            if (reload_we) m_reload = int'(reload_wdata);
            m_mode = nm;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        if (rst_n) begin
            chk(scl_low_o == ((m_mode == 1 || m_mode == 4 || (m_mode == 0 && m_park)) ? 1'b1 : 1'b0),
                "R1", "scl_low_o", int'(scl_low_o), int'(m_mode));
            chk(sda_low_o == ((m_mode >= 4 && !m_ackv) ? 1'b1 : 1'b0), "R7", "sda_low_o",
                int'(sda_low_o), int'(m_ackv));
            chk(rcv_busy == (m_mode >= 1 && m_mode <= 3), "R9", "rcv_busy", int'(rcv_busy), m_mode);
            chk(ack_busy == (m_mode >= 4), "R9", "ack_busy", int'(ack_busy), m_mode);
            chk(buf_full == m_full, "R3", "buf_full", int'(buf_full), int'(m_full));
            chk(irq_flag == m_irq, "R10", "irq_flag", int'(irq_flag), int'(m_irq));
            chk(ovf_flag == m_ovf, "R5", "ovf_flag", int'(ovf_flag), int'(m_ovf));
            chk(wcol_flag == m_wcol, "R6", "wcol_flag", int'(wcol_flag), int'(m_wcol));
            chk(rd_data == m_buf, "R3", "rd_data", int'(rd_data), int'(m_buf));
        end
    end

    task automatic start_rx(input logic [7:0] b);
        @(negedge clk);
        slv_byte = b; slv_rises = 0; slv_on = 1'b1; slv_sda_low = !b[7];
        rcv_go = 1'b1;
        @(negedge clk);
        rcv_go = 1'b0;
    endtask

    task automatic start_ack(input logic v);
        @(negedge clk);
        ack_bit = v; ack_go = 1'b1;
        @(negedge clk);
        ack_go = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 5000; i++) begin
            if (!rcv_busy && !ack_busy) break;
            @(negedge clk);
        end
        repeat (8) @(negedge clk);
    endtask

    task automatic pulse_rd();
        @(negedge clk); buf_rd = 1'b1; @(negedge clk); buf_rd = 1'b0;
    endtask

    task automatic set_reload(input logic [7:0] v);
        @(negedge clk); reload_we = 1'b1; reload_wdata = v;
        @(negedge clk); reload_we = 1'b0;
    endtask

    task automatic first_low_len(input logic [7:0] b, input int exp);
        int n;
        n = 0;
        start_rx(b);
        // start_rx returns at the first negedge after the command edge
        while (rcv_busy && scl_low_o) begin n++; @(negedge clk); end
        chk(n == exp, "R1", "first low phase length", n, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(scl_low_o == 0 && sda_low_o == 0, "R11", "pins released in reset",
            int'({scl_low_o, sda_low_o}), 0);
        chk({buf_full, ovf_flag, wcol_flag, irq_flag} == 4'b0 && rd_data == 8'h00,
            "R11", "flags and buffer in reset", int'({buf_full, ovf_flag, wcol_flag, irq_flag}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // reset reload value gives RLD_RST+1 low clocks
        first_low_len(8'hA5, RLD_RST + 1);
        wait_idle();
        chk(rd_data == 8'hA5, "R2", "received byte", int'(rd_data), 8'hA5);
        chk(buf_full && irq_flag && scl_low_o && !rcv_busy, "R3", "completion state",
            int'({buf_full, irq_flag, scl_low_o, rcv_busy}), 4'b1110);
        pulse_rd();
        chk(!buf_full, "R4", "read clears full", int'(buf_full), 0);

        start_ack(1'b0);
        @(negedge clk);
        chk(sda_low_o && scl_low_o, "R7", "ACK drives SDA low", int'({sda_low_o, scl_low_o}), 3);
        wait_idle();
        start_ack(1'b1);
        @(negedge clk);
        chk(!sda_low_o && ack_busy, "R7", "NACK leaves SDA free", int'({sda_low_o, ack_busy}), 1);
        wait_idle();

        set_reload(8'd3);
        stretch_en = 1'b1;
        first_low_len(8'h3C, 4);
        wait_idle();
        stretch_en = 1'b0;
        repeat (10) @(negedge clk);
        chk(rd_data == 8'h3C, "R8", "byte under stretching", int'(rd_data), 8'h3C);

        // overflow: buffer still full from 0x3C
        start_rx(8'h5A);
        wait_idle();
        chk(ovf_flag && rd_data == 8'h3C, "R5", "overflow keeps old byte",
            int'(rd_data), 8'h3C);
        @(negedge clk); clr_ovf = 1'b1; clr_irq = 1'b1;
        @(negedge clk); clr_ovf = 1'b0; clr_irq = 1'b0;
        chk(!ovf_flag && !irq_flag && buf_full, "R10", "clear strobes",
            int'({ovf_flag, irq_flag, buf_full}), 1);
        pulse_rd();

        // write collision during reception
        start_rx(8'h81);
        repeat (6) @(negedge clk);
        buf_wr = 1'b1; buf_wdata = 8'hFF;
        @(negedge clk); buf_wr = 1'b0;
        chk(wcol_flag, "R6", "collision flagged", int'(wcol_flag), 1);
        // acknowledge command while receiving is ignored
        ack_go = 1'b1; ack_bit = 1'b0;
        @(negedge clk); ack_go = 1'b0;
        chk(!ack_busy && rcv_busy, "R9", "ack ignored while busy", int'({ack_busy, rcv_busy}), 1);
        wait_idle();
        chk(rd_data == 8'h81, "R6", "buffer unchanged by collision", int'(rd_data), 8'h81);
        chk(!ack_busy, "R9", "no late ack", int'(ack_busy), 0);

        // idle write loads the buffer, then clear and set together
        @(negedge clk); buf_wr = 1'b1; buf_wdata = 8'h42;
        @(negedge clk); buf_wr = 1'b0;
        chk(rd_data == 8'h42 && wcol_flag, "R6", "idle write loads buffer", int'(rd_data), 8'h42);
        @(negedge clk); clr_wcol = 1'b1;
        @(negedge clk); clr_wcol = 1'b0;
        chk(!wcol_flag, "R10", "wcol cleared", int'(wcol_flag), 0);
        pulse_rd();

        // both commands together: receive wins; minimum reload
        set_reload(8'd0);
        @(negedge clk);
        slv_byte = 8'h96; slv_rises = 0; slv_on = 1'b1; slv_sda_low = 1'b0;
        rcv_go = 1'b1; ack_go = 1'b1;
        @(negedge clk); rcv_go = 1'b0; ack_go = 1'b0;
        chk(rcv_busy && !ack_busy, "R9", "receive wins", int'({rcv_busy, ack_busy}), 2);
        wait_idle();
        chk(rd_data == 8'h96, "R2", "byte at reload 0", int'(rd_data), 8'h96);
        pulse_rd();
        first_low_len(8'h01, 1);
        wait_idle();
        chk(rd_data == 8'h01, "R2", "second byte at reload 0", int'(rd_data), 8'h01);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule